// File: doc/BRIEF.md
# Serial-Line CRC-16 Generator and Checker

This block computes the 16-bit cyclic redundancy code that protects frames on a serial field bus. Message bytes arrive on a valid/ready handshake. Each accepted byte is folded into a 16-bit register that starts at all ones. The register then advances one bit position per clock toward the least significant end, with a conditional XOR of the reflected polynomial 0xA001. A byte therefore occupies the unit for exactly eight clocks. Only the eight data bits of a character enter the calculation; framing and parity bits never reach this block.

On the sending side, an end-of-message strobe makes the unit emit its two code bytes on a byte output, the low-order byte first. On the receiving side, the whole frame is fed in, including its two trailing code bytes. An end-of-frame strobe then compares the code computed over the payload with those trailing bytes, and pulses a match or a mismatch flag for one cycle. A start-of-frame input restarts the calculation at any moment.

Top module: `crc16_serial_unit`

## Requirements
- R1: A cycle with `sof` high and `in_valid` low sets `crc_value` to 0xFFFF and `in_ready` to 1 from the next cycle, aborting any byte still being shifted.
- R2: While `rst` is high, and in the first cycle after it falls, `crc_value` is 0xFFFF, `in_ready` is 1, and `out_valid`, `crc_ok` and `crc_err` are 0.
- R3: Per accepted byte, the byte is XORed into bits [7:0] of the register. Then eight times the register moves one place right with a zero into bit 15, and it is XORed with 0xA001 whenever the bit that left bit 0 was 1. After payload 0x0D,0x01,0x00,0x62,0x00,0x33 from a fresh start, `crc_value` is 0x0DDD.
- R4: A byte is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is then low for exactly seven cycles, so bytes are taken at most once every eight clocks. `crc_value` holds the final result from the cycle in which `in_ready` returns high.
- R5: `tx_eom` sampled while `in_ready` is high and no byte is accepted makes `out_valid` high for the next two cycles. `out_data` carries `crc_value[7:0]` in the first of them and `crc_value[15:8]` in the second, and `out_valid` is low after that.
- R6: `tx_eom` sampled while a byte is being shifted (or accepted) is held pending. The two code bytes are emitted once that byte is finished, and they include it.
- R7: On `rx_eof`, the last two bytes accepted are taken as the received code, the earlier one as the low byte. They are compared with the code over all bytes accepted before them since the last `sof`. In the next cycle exactly one of `crc_ok` (equal) and `crc_err` (unequal) is high, and both are low in any cycle not preceded by `rx_eof`.
- R8: `rx_eof` with fewer than two bytes accepted since the last `sof` yields `crc_err`.
- R9: A cycle with `sof` and `in_valid` high while `in_ready` is high accepts that byte as the first byte of a fresh message, computed from 0xFFFF.
- R10: `tx_eom` sampled while the two code bytes are already being emitted has no effect: `out_valid` still falls after the second byte and stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | Start of frame: reload the register with all ones |
| in_valid | input | 1 | A message byte is offered |
| in_data | input | 8 | Message byte |
| in_ready | output | 1 | Unit can take a byte this cycle |
| tx_eom | input | 1 | End of message on the send side: emit the code |
| rx_eof | input | 1 | End of frame on the receive side: compare the trailing code |
| out_valid | output | 1 | `out_data` carries a code byte |
| out_data | output | 8 | Code byte, low-order byte first |
| crc_value | output | 16 | Current content of the CRC register |
| crc_ok | output | 1 | One-cycle pulse: received code matches |
| crc_err | output | 1 | One-cycle pulse: received code differs or frame too short |

## Verification
A byte taken at one edge leaves `in_ready` low for seven cycles. The final `crc_value` is therefore due eight edges after acceptance, and the bench waits for `in_ready` before comparing against its own bit-serial model. Code bytes appear one edge after a `tx_eom` sampled while idle, and the match flags appear one edge after `rx_eof`. The bench drives every input on the falling clock edge and samples on the next falling edge, so every check lands half a cycle after the register that produces it. A deferred `tx_eom` has no fixed latency, so the bench polls for the rising `out_valid` within a bounded window and then checks the two bytes in consecutive cycles.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned CRC_W    = 16;
  localparam logic [15:0] POLY_REF = 16'hA001;
  localparam logic [15:0] PRESET   = 16'hFFFF;

  typedef enum logic [1:0] {
    EMIT_IDLE = 2'd0,
    EMIT_PEND = 2'd1,
    EMIT_SEND = 2'd2
  } emit_state_t;
endpackage

// File: rtl/crc16_step_unit.sv
module crc16_step_unit #(
  parameter int unsigned DATA_W = crc16_pkg::DATA_W,
  parameter int unsigned CRC_W  = crc16_pkg::CRC_W,
  parameter logic [CRC_W-1:0] POLY   = crc16_pkg::POLY_REF,
  parameter logic [CRC_W-1:0] PRESET = crc16_pkg::PRESET
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sof,
  input  logic              accept,
  input  logic [DATA_W-1:0] byte_in,
  output logic              busy,
  output logic [CRC_W-1:0]  crc_q
);
  localparam int unsigned CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] SHIFTS_LEFT = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CRC_W-1:0] base;
  logic [CRC_W-1:0] folded;

  function automatic logic [CRC_W-1:0] shift_once(input logic [CRC_W-1:0] c);
    logic [CRC_W-1:0] s;
    s = c >> 1;
    if (c[0]) s = s ^ POLY;
    return s;
  endfunction

  always_comb begin
    base   = sof ? PRESET : crc_q;
    folded = base ^ {{(CRC_W-DATA_W){1'b0}}, byte_in};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q <= PRESET;
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (accept) begin
      crc_q <= shift_once(folded);
      busy  <= 1'b1;
      cnt_q <= SHIFTS_LEFT;
    end else if (sof) begin
      crc_q <= PRESET;
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (busy) begin
      crc_q <= shift_once(crc_q);
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/crc16_tx_emit.sv
module crc16_tx_emit #(
  parameter int unsigned DATA_W = crc16_pkg::DATA_W,
  parameter int unsigned CRC_W  = crc16_pkg::CRC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sof,
  input  logic              eom,
  input  logic              core_idle,
  input  logic [CRC_W-1:0]  crc_q,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  import crc16_pkg::*;
  localparam int unsigned NBYTES = CRC_W / DATA_W;
  localparam int unsigned IDX_W  = $clog2(NBYTES + 1);

  emit_state_t      state_q;
  logic [CRC_W-1:0] rest_q;
  logic [IDX_W-1:0] idx_q;
  logic             start;

  always_comb begin
    start = 1'b0;
    if (core_idle) begin
      if (state_q == EMIT_PEND) start = 1'b1;
      if (state_q == EMIT_IDLE && eom) start = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || sof) begin
      state_q   <= EMIT_IDLE;
      out_valid <= 1'b0;
      out_data  <= '0;
      rest_q    <= '0;
      idx_q     <= '0;
    end else if (start) begin
      state_q   <= EMIT_SEND;
      out_valid <= 1'b1;
      out_data  <= crc_q[DATA_W-1:0];
      rest_q    <= crc_q >> DATA_W;
      idx_q     <= IDX_W'(NBYTES - 1);
    end else begin
      case (state_q)
        EMIT_IDLE: if (eom) state_q <= EMIT_PEND;
        EMIT_SEND: begin
          if (idx_q == '0) begin
            state_q   <= EMIT_IDLE;
            out_valid <= 1'b0;
          end else begin
            out_data <= rest_q[DATA_W-1:0];
            rest_q   <= rest_q >> DATA_W;
            idx_q    <= idx_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/crc16_rx_cmp.sv
module crc16_rx_cmp #(
  parameter int unsigned DATA_W = crc16_pkg::DATA_W,
  parameter int unsigned CRC_W  = crc16_pkg::CRC_W,
  parameter logic [CRC_W-1:0] PRESET = crc16_pkg::PRESET
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sof,
  input  logic              accept,
  input  logic [DATA_W-1:0] byte_in,
  input  logic [CRC_W-1:0]  crc_q,
  input  logic              eof,
  output logic              ok,
  output logic              err
);
  localparam int unsigned NBYTES = CRC_W / DATA_W;
  localparam int unsigned NCNT_W = $clog2(NBYTES + 1);

  logic [CRC_W-1:0]  hist_q  [NBYTES];
  logic [DATA_W-1:0] tail_q  [NBYTES];
  logic [NCNT_W-1:0] count_q;
  logic [CRC_W-1:0]  field;
  logic              match;

  genvar g;
  generate
    for (g = 0; g < NBYTES; g++) begin : g_field
      assign field[g*DATA_W +: DATA_W] = tail_q[NBYTES-1-g];
    end
  endgenerate

  assign match = (count_q == NCNT_W'(NBYTES)) && (hist_q[NBYTES-1] == field);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      for (int i = 0; i < NBYTES; i++) begin
        hist_q[i] <= PRESET;
        tail_q[i] <= '0;
      end
    end else if (accept) begin
      hist_q[0] <= sof ? PRESET : crc_q;
      tail_q[0] <= byte_in;
      for (int i = 1; i < NBYTES; i++) begin
        hist_q[i] <= hist_q[i-1];
        tail_q[i] <= tail_q[i-1];
      end
      if (sof) count_q <= NCNT_W'(1);
      else if (count_q != NCNT_W'(NBYTES)) count_q <= count_q + 1'b1;
    end else if (sof) begin
      count_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ok  <= 1'b0;
      err <= 1'b0;
    end else begin
      ok  <= eof && match;
      err <= eof && !match;
    end
  end
endmodule

// File: rtl/crc16_serial_unit.sv
module crc16_serial_unit #(
  parameter int unsigned DATA_W = crc16_pkg::DATA_W,
  parameter int unsigned CRC_W  = crc16_pkg::CRC_W,
  parameter logic [CRC_W-1:0] POLY   = crc16_pkg::POLY_REF,
  parameter logic [CRC_W-1:0] PRESET = crc16_pkg::PRESET
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sof,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              tx_eom,
  input  logic              rx_eof,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [CRC_W-1:0]  crc_value,
  output logic              crc_ok,
  output logic              crc_err
);
  logic busy;
  logic accept;

  assign in_ready = !busy;
  assign accept   = in_valid && !busy;

  crc16_step_unit #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY), .PRESET(PRESET)) core_i (
    .clk(clk), .rst(rst), .sof(sof), .accept(accept), .byte_in(in_data),
    .busy(busy), .crc_q(crc_value)
  );

  crc16_tx_emit #(.DATA_W(DATA_W), .CRC_W(CRC_W)) tx_i (
    .clk(clk), .rst(rst), .sof(sof), .eom(tx_eom), .core_idle(!busy && !accept),
    .crc_q(crc_value), .out_valid(out_valid), .out_data(out_data)
  );

  crc16_rx_cmp #(.DATA_W(DATA_W), .CRC_W(CRC_W), .PRESET(PRESET)) rx_i (
    .clk(clk), .rst(rst), .sof(sof), .accept(accept), .byte_in(in_data),
    .crc_q(crc_value), .eof(rx_eof), .ok(crc_ok), .err(crc_err)
  );
endmodule

// File: rtl/crc16_serial_unit_chk.sv
module crc16_serial_unit_chk #(
  parameter int unsigned CRC_W = crc16_pkg::CRC_W,
  parameter logic [CRC_W-1:0] PRESET = crc16_pkg::PRESET
) (
  input logic             clk,
  input logic             rst,
  input logic             sof,
  input logic             in_valid,
  input logic             in_ready,
  input logic             rx_eof,
  input logic             out_valid,
  input logic [CRC_W-1:0] crc_value,
  input logic             crc_ok,
  input logic             crc_err
);
  a_r1_sof_preset: assert property (@(posedge clk) disable iff (rst)
    (sof && !in_valid) |=> (crc_value == PRESET && in_ready));

  a_r4_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  a_r7_result_follows_eof: assert property (@(posedge clk) disable iff (rst)
    rx_eof |=> (crc_ok || crc_err));

  a_r7_result_needs_eof: assert property (@(posedge clk) disable iff (rst)
    (crc_ok || crc_err) |-> $past(rx_eof));

  a_r7_ok_err_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(crc_ok && crc_err));

  a_r5_two_byte_burst: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid)) |=> !out_valid);
endmodule

bind crc16_serial_unit crc16_serial_unit_chk #(.CRC_W(CRC_W), .PRESET(PRESET)) chk_i (
  .clk(clk), .rst(rst), .sof(sof), .in_valid(in_valid), .in_ready(in_ready),
  .rx_eof(rx_eof), .out_valid(out_valid), .crc_value(crc_value),
  .crc_ok(crc_ok), .crc_err(crc_err)
);

// File: tb/crc16_serial_unit_tb.sv
module crc16_serial_unit_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sof = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready;
  logic       tx_eom = 1'b0;
  logic       rx_eof = 1'b0;
  logic       out_valid;
  logic [7:0] out_data;
  logic [15:0] crc_value;
  logic       crc_ok;
  logic       crc_err;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc16_serial_unit dut_i (
    .clk(clk), .rst(rst), .sof(sof), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .tx_eom(tx_eom), .rx_eof(rx_eof), .out_valid(out_valid),
    .out_data(out_data), .crc_value(crc_value), .crc_ok(crc_ok), .crc_err(crc_err)
  );

  function automatic logic [15:0] ref_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int k = 0; k < 8; k++) begin
      if (r[0]) r = (r >> 1) ^ 16'hA001;
      else      r = r >> 1;
    end
    return r;
  endfunction

  task automatic check(input bit cond, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!in_ready) @(negedge clk);
  endtask

  task automatic pulse_sof();
    wait_idle();
    sof = 1'b1;
    @(negedge clk);
    sof = 1'b0;
  endtask

  task automatic emit_check(input logic [15:0] exp, input string req);
    tx_eom = 1'b1;
    @(negedge clk);
    tx_eom = 1'b0;
    check(out_valid && out_data == exp[7:0], req, {out_valid, out_data}, {1'b1, exp[7:0]});
    @(negedge clk);
    check(out_valid && out_data == exp[15:8], req, {out_valid, out_data}, {1'b1, exp[15:8]});
    @(negedge clk);
    check(!out_valid, req, out_valid, 0);
  endtask

  task automatic rx_check(input bit expect_ok, input string req);
    rx_eof = 1'b1;
    @(negedge clk);
    rx_eof = 1'b0;
    check(crc_ok == expect_ok && crc_err == !expect_ok, req, {crc_ok, crc_err}, {expect_ok, !expect_ok});
    @(negedge clk);
    check(!crc_ok && !crc_err, req, {crc_ok, crc_err}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0]  vec [6];
    logic [15:0] exp;
    int lowc;
    void'($urandom(32'hC0FFEE));
    vec[0] = 8'h0D; vec[1] = 8'h01; vec[2] = 8'h00;
    vec[3] = 8'h62; vec[4] = 8'h00; vec[5] = 8'h33;

    // R2: reset state
    repeat (3) @(negedge clk);
    check(crc_value == 16'hFFFF && in_ready && !out_valid && !crc_ok && !crc_err,
          "R2", {crc_value, in_ready, out_valid, crc_ok, crc_err}, {16'hFFFF, 4'b1000});
    rst = 1'b0;
    @(negedge clk);
    check(crc_value == 16'hFFFF && in_ready && !out_valid, "R2", crc_value, 16'hFFFF);

    // R3: known vector, R5: emission
    pulse_sof();
    for (int i = 0; i < 6; i++) send_byte(vec[i]);
    wait_idle();
    check(crc_value == 16'h0DDD, "R3", crc_value, 16'h0DDD);
    emit_check(16'h0DDD, "R5");

    // R4: ready low for exactly seven cycles after accept
    pulse_sof();
    send_byte(8'hA5);
    lowc = 0;
    while (!in_ready && lowc < 20) begin lowc++; @(negedge clk); end
    check(lowc == 7, "R4", lowc, 7);
    check(crc_value == ref_byte(16'hFFFF, 8'hA5), "R4", crc_value, ref_byte(16'hFFFF, 8'hA5));

    // R6: end of message during shifting is deferred and includes the byte
    pulse_sof();
    send_byte(8'h3C);
    tx_eom = 1'b1;
    @(negedge clk);
    tx_eom = 1'b0;
    exp = ref_byte(16'hFFFF, 8'h3C);
    lowc = 0;
    while (!out_valid && lowc < 20) begin lowc++; @(negedge clk); end
    check(out_valid && out_data == exp[7:0], "R6", out_data, exp[7:0]);
    @(negedge clk);
    check(out_valid && out_data == exp[15:8], "R6", out_data, exp[15:8]);

    // R10: repeated end of message during emission is ignored
    wait_idle();
    @(negedge clk);
    tx_eom = 1'b1;
    @(negedge clk);
    check(out_valid && out_data == exp[7:0], "R10", out_data, exp[7:0]);
    @(negedge clk);
    tx_eom = 1'b0;
    check(out_valid && out_data == exp[15:8], "R10", out_data, exp[15:8]);
    @(negedge clk);
    check(!out_valid, "R10", out_valid, 0);
    @(negedge clk);
    check(!out_valid, "R10", out_valid, 0);

    // R1: start of frame aborts a byte in progress
    pulse_sof();
    send_byte(8'hFF);
    @(negedge clk);
    sof = 1'b1;
    @(negedge clk);
    sof = 1'b0;
    check(crc_value == 16'hFFFF && in_ready, "R1", crc_value, 16'hFFFF);

    // R9: start of frame together with a byte
    send_byte(8'h11);
    wait_idle();
    sof = 1'b1; in_valid = 1'b1; in_data = 8'h5A;
    @(negedge clk);
    sof = 1'b0; in_valid = 1'b0;
    wait_idle();
    check(crc_value == ref_byte(16'hFFFF, 8'h5A), "R9", crc_value, ref_byte(16'hFFFF, 8'h5A));

    // R8: too short frame
    pulse_sof();
    send_byte(8'h42);
    wait_idle();
    rx_check(1'b0, "R8");

    // R7: directed good frame from the known vector
    pulse_sof();
    for (int i = 0; i < 6; i++) send_byte(vec[i]);
    send_byte(8'hDD);
    send_byte(8'h0D);
    rx_check(1'b1, "R7");

    // R3/R5/R7 random messages
    for (int t = 0; t < 40; t++) begin
      int n;
      logic [7:0] msg [16];
      bit corrupt;
      n = 1 + int'($urandom_range(15));
      exp = 16'hFFFF;
      pulse_sof();
      for (int i = 0; i < n; i++) begin
        msg[i] = 8'($urandom);
        exp = ref_byte(exp, msg[i]);
        send_byte(msg[i]);
      end
      wait_idle();
      check(crc_value == exp, "R3", crc_value, exp);
      emit_check(exp, "R5");
      corrupt = ($urandom_range(2) == 0);
      pulse_sof();
      for (int i = 0; i < n; i++) send_byte(msg[i]);
      send_byte(exp[7:0] ^ (corrupt ? 8'h01 : 8'h00));
      send_byte(exp[15:8]);
      rx_check(!corrupt, "R7");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule